// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Latch Readback

This block models an eight-pin general-purpose port that has no direction register. Each pin owns an output latch. A latch holding 0 switches on a strong pull-down and forces the pin to ground. A latch holding 1 leaves the pin to a weak internal pull-up, so an outside driver can pull the pin low. A pin therefore works as an input only after software has written a 1 into its latch.

The processor side has three operations. A write strobe loads all latches at once. Two read strobes return data: one returns the resolved pin levels and the other returns the stored latch contents. A single-bit read-modify-write path clears, sets or toggles one latch bit. It works from the latch value, never from the pin, so a bit held low from outside does not corrupt the stored value.

On the pin side, each pin has a driven-low flag and a resolved level. The resolved level combines the internal pull-down with an external pull-low input.

Top module: `qbp_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every latch loads 1, `rd_data` clears to 0 and `rd_valid` clears to 0. After reset no pin is driven low.
- R2: When `wr_en` is high at a clock edge, all latches take `wr_data`. From the next cycle `pin_drive_low` equals the inverse of the latch.
- R3: `pin_level[i]` is 0 when bit i is driven low internally or when `ext_pull_low[i]` is 1. Otherwise it is 1. This relation is combinational.
- R4: When `rd_pin_en` is high at an edge and `rd_latch_en` is low, `rd_data` holds the `pin_level` value seen at that edge in the following cycle, with `rd_valid` high for that one cycle.
- R5: A read through `rd_latch_en` returns the latch contents one cycle later, whatever the external pull-low inputs are doing.
- R6: If both read strobes are high in the same cycle, the latch contents are returned.
- R7: When `rmw_en` is high (and `wr_en` low), latch bit `rmw_bit` is updated by `rmw_op`. The encodings are 2'b00 clear, 2'b01 set and 2'b10 toggle. All other bits keep their value.
- R8: When `wr_en` and `rmw_en` are both high, the full write wins and the bit operation is dropped.
- R9: A read-modify-write works on the latch value. Toggling a bit whose latch is 1 while its pin is pulled low from outside yields 0.
- R10: In cycles with no read strobe, `rd_valid` is 0 and `rd_data` keeps its last value.
- R11: `rmw_op` 2'b11 leaves the selected latch bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Load all latches from `wr_data` |
| wr_data | input | WIDTH | Latch write data |
| rmw_en | input | 1 | Apply a single-bit operation to a latch |
| rmw_op | input | 2 | 00 clear, 01 set, 10 toggle, 11 keep |
| rmw_bit | input | IDXW | Index of the bit to modify |
| rd_pin_en | input | 1 | Return the resolved pin levels |
| rd_latch_en | input | 1 | Return the latch contents |
| ext_pull_low | input | WIDTH | External driver pulling each pin low |
| pin_drive_low | output | WIDTH | Internal pull-down active per pin |
| pin_level | output | WIDTH | Resolved level of each pin |
| rd_data | output | WIDTH | Read result |
| rd_valid | output | 1 | Read result presented this cycle |

## Verification
The bench goes after four corner cases.

The first is the difference between the two read paths while an external source holds pins low. A design that muddled them would report the pulled-low bits as 0 on a latch read, or as 1 on a pin read.

The second is toggling a bit whose pin is held low while its latch holds 1. A design that took the operand from the pin would store 1 instead of 0.

The third covers collisions: both read strobes together, and a write together with a bit operation. A wrong priority returns pin data, or leaves a stray bit set on top of the written byte.

The fourth is reset and the keep encoding. A wrong reset value leaves pins driven low. A wrong keep decode changes a bit that should stay put.

// File: rtl/qbp_pkg.sv
// Package: shared encodings for the quasi-bidirectional port.
// Assumes: the bit operation code is two bits wide.
package qbp_pkg;

    typedef enum logic [1:0] {
        RMW_CLR  = 2'b00,
        RMW_SET  = 2'b01,
        RMW_TGL  = 2'b10,
        RMW_KEEP = 2'b11
    } rmw_op_e;

    // Next value of one latch bit under a single-bit operation.
    function automatic logic rmw_apply(input logic [1:0] op, input logic cur);
        case (rmw_op_e'(op))
            RMW_CLR: rmw_apply = 1'b0;
            RMW_SET: rmw_apply = 1'b1;
            RMW_TGL: rmw_apply = ~cur;
            default: rmw_apply = cur;
        endcase
    endfunction

endpackage

// File: rtl/qbp_latch_bank.sv
// Module: output latches of the port.
// A full write loads every bit. A single-bit operation changes only the
// selected bit, with the full write taking priority.
// Assumes: WIDTH is a power of two, so every index value names a bit.
module qbp_latch_bank #(
    parameter int WIDTH = 8,
    parameter int IDXW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [IDXW-1:0]  rmw_bit,
    output logic [WIDTH-1:0] latch_q
);
    import qbp_pkg::*;

    localparam logic [WIDTH-1:0] RESET_ALL_ONES = '1;

    logic [WIDTH-1:0] latch_d;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            // Pick the next value of this bit: write, bit operation or hold.
            always_comb begin
                if (wr_en)
                    latch_d[gi] = wr_data[gi];
                else if (rmw_en && (rmw_bit == IDXW'(gi)))
                    latch_d[gi] = rmw_apply(rmw_op, latch_q[gi]);
                else
                    latch_d[gi] = latch_q[gi];
            end
        end
    endgenerate

    // Latch register; reset makes every pin a pulled-up input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= RESET_ALL_ONES;
        else
            latch_d_apply: latch_q <= latch_d;
    end

    assert_reset_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (latch_q == RESET_ALL_ONES));

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (latch_q == $past(wr_data)));

    assert_rmw_other_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rmw_en) && !$past(wr_en)) |->
        (((latch_q ^ $past(latch_q)) & ~(WIDTH'(1) << $past(rmw_bit))) == '0));

    assert_keep_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rmw_en) && !$past(wr_en) && ($past(rmw_op) == 2'b11))
        |-> $stable(latch_q));

endmodule

// File: rtl/qbp_pad_resolve.sv
// Module: per-pin electrical model.
// A latch holding 0 turns the pull-down on. A pin reads high only when
// neither the pull-down nor an external driver pulls it low.
// Assumes: the external pull-low always overpowers the weak pull-up.
module qbp_pad_resolve #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] ext_pull_low,
    output logic [WIDTH-1:0] pin_drive_low,
    output logic [WIDTH-1:0] pin_level
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_pad
            // Resolve the pull-down, the pull-up and the external driver for one pin.
            always_comb begin
                pin_drive_low[gi] = ~latch_q[gi];
                pin_level[gi]     = ~(pin_drive_low[gi] | ext_pull_low[gi]);
            end
        end
    endgenerate

    assert_driven_pin_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & (pin_drive_low | ext_pull_low)) == '0);

    assert_released_pin_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (~pin_level & ~pin_drive_low & ~ext_pull_low) == '0);

endmodule

// File: rtl/qbp_read_path.sv
// Module: registered read port.
// Samples either the pin levels or the latch contents. The latch read wins
// when both strobes are high. The result holds until the next read.
// Assumes: each read strobe lasts one cycle per read.
module qbp_read_path #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_pin_en,
    input  logic             rd_latch_en,
    input  logic [WIDTH-1:0] pin_level,
    input  logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid
);
    // Capture the selected source and flag the result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_pin_en | rd_latch_en;
            if (rd_latch_en)
                rd_data <= latch_q;
            else if (rd_pin_en)
                rd_data <= pin_level;
        end
    end

    assert_pin_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_pin_en) && !$past(rd_latch_en)) |->
        (rd_valid && (rd_data == $past(pin_level))));

    assert_latch_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_latch_en)) |-> (rd_valid && (rd_data == $past(latch_q))));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_pin_en) && !$past(rd_latch_en)) |->
        (!rd_valid && $stable(rd_data)));

endmodule

// File: rtl/qbp_port.sv
// Module: top of the quasi-bidirectional port.
// Ties the latch bank, the pin model and the read path together.
// Assumes: the read strobes are not raised together in normal use. If they
// are, the latch read wins.
module qbp_port #(
    parameter int WIDTH = 8,
    parameter int IDXW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [IDXW-1:0]  rmw_bit,
    input  logic             rd_pin_en,
    input  logic             rd_latch_en,
    input  logic [WIDTH-1:0] ext_pull_low,
    output logic [WIDTH-1:0] pin_drive_low,
    output logic [WIDTH-1:0] pin_level,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid
);
    logic [WIDTH-1:0] latch_q;

    qbp_latch_bank #(.WIDTH(WIDTH), .IDXW(IDXW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rmw_en  (rmw_en),
        .rmw_op  (rmw_op),
        .rmw_bit (rmw_bit),
        .latch_q (latch_q)
    );

    qbp_pad_resolve #(.WIDTH(WIDTH)) u_pad (
        .clk           (clk),
        .rst_n         (rst_n),
        .latch_q       (latch_q),
        .ext_pull_low  (ext_pull_low),
        .pin_drive_low (pin_drive_low),
        .pin_level     (pin_level)
    );

    qbp_read_path #(.WIDTH(WIDTH)) u_read (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_pin_en   (rd_pin_en),
        .rd_latch_en (rd_latch_en),
        .pin_level   (pin_level),
        .latch_q     (latch_q),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    assert_write_beats_rmw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(rmw_en)) |-> (pin_drive_low == ~$past(wr_data)));

endmodule

// File: tb/qbp_port_tb.sv
// Scoreboard bench for qbp_port. The driver tasks push expected read
// results into a queue, and a monitor pops and compares them on each rd_valid.
module qbp_port_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rmw_en = 1'b0;
    logic [1:0]   rmw_op = 2'b11;
    logic [2:0]   rmw_bit = '0;
    logic         rd_pin_en = 1'b0;
    logic         rd_latch_en = 1'b0;
    logic [W-1:0] ext_pull_low = '0;
    logic [W-1:0] pin_drive_low;
    logic [W-1:0] pin_level;
    logic [W-1:0] rd_data;
    logic         rd_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [W-1:0] model_latch = '1;
    logic [W-1:0] last_rd = '0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #2.5 clk = ~clk;

    qbp_port #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_bit(rmw_bit),
        .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en),
        .ext_pull_low(ext_pull_low), .pin_drive_low(pin_drive_low),
        .pin_level(pin_level), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: every valid read must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected rd_valid", rd_data, last_rd);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
                last_rd = rd_data;
            end
        end
    end

    function automatic logic [W-1:0] model_pins();
        return model_latch & ~ext_pull_low;
    endfunction

    task automatic do_write(input logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        model_latch = d;
    endtask

    task automatic do_rmw(input logic [1:0] op, input int b);
        @(negedge clk); rmw_en = 1'b1; rmw_op = op; rmw_bit = 3'(b);
        @(negedge clk); rmw_en = 1'b0;
        case (op)
            2'b00: model_latch[b] = 1'b0;
            2'b01: model_latch[b] = 1'b1;
            2'b10: model_latch[b] = ~model_latch[b];
            default: ;
        endcase
    endtask

    task automatic do_read(input bit pin_s, input bit latch_s, input string tag);
        @(negedge clk);
        rd_pin_en = pin_s; rd_latch_en = latch_s;
        exp_q.push_back(latch_s ? model_latch : model_pins());
        tag_q.push_back(tag);
        @(negedge clk);
        rd_pin_en = 1'b0; rd_latch_en = 1'b0;
    endtask

    task automatic check_pins(input string tag);
        check(pin_drive_low == ~model_latch, {tag, " drive_low"}, pin_drive_low, ~model_latch);
        check(pin_level == model_pins(), {tag, " pin_level"}, pin_level, model_pins());
    endtask

    initial begin
        #(5 * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        check(rd_valid == 1'b0, "R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 8'h00);
        check_pins("R1");
        do_read(1'b0, 1'b1, "R1 R5 latch read after reset");
        do_read(1'b1, 1'b0, "R4 pin read all high");

        // R3 R5: external pulls do not reach the latch read
        ext_pull_low = 8'h0F;
        #1;
        check_pins("R3 ext low");
        do_read(1'b1, 1'b0, "R4 pin read with ext low");
        do_read(1'b0, 1'b1, "R5 latch read with ext low");

        // R2: full write
        do_write(8'hA5);
        check_pins("R2 after write");
        do_read(1'b1, 1'b0, "R4 pin read after write");
        do_read(1'b0, 1'b1, "R5 latch read after write");
        do_read(1'b1, 1'b1, "R6 both strobes latch wins");

        // R9: toggle bit 0, whose latch is 1 and whose pin is pulled low
        do_rmw(2'b10, 0);
        do_read(1'b0, 1'b1, "R9 R7 toggle uses latch");
        do_rmw(2'b01, 6);
        do_rmw(2'b00, 7);
        do_read(1'b0, 1'b1, "R7 set and clear");
        do_rmw(2'b11, 2);
        do_read(1'b0, 1'b1, "R11 keep leaves bit");
        check_pins("R7 pins after rmw");

        // R8: write and bit operation together
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h3C; rmw_en = 1'b1; rmw_op = 2'b01; rmw_bit = 3'd0;
        @(negedge clk);
        wr_en = 1'b0; rmw_en = 1'b0;
        model_latch = 8'h3C;
        do_read(1'b0, 1'b1, "R8 write beats rmw");

        // R10: idle cycles hold the result
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(rd_valid == 1'b0, "R10 idle valid", {7'd0, rd_valid}, 8'h00);
            check(rd_data == 8'h3C, "R10 idle hold", rd_data, 8'h3C);
        end

        ext_pull_low = 8'h00;
        do_write(8'hFF);
        do_read(1'b1, 1'b0, "R3 R4 released pins high");
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R4 scoreboard drained", 8'(exp_q.size()), 8'h00);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule